// File: doc/BRIEF.md
# Transmit Buffer Ready-Request Register

This block keeps one pending-transmission flag for each message buffer of a CAN FD controller. Host software raises flags through a set-only write port: a 1 in the write data raises the flag of that buffer, and a 0 leaves it as it is. The protocol core lowers a flag when the buffer's frame has been sent, when the buffer is cancelled, or, in single-shot mode, when any transmission attempt of that buffer ends. The flag vector is always visible on an output, and a read has no side effects.

Every host write, whatever its data, also asks the buffer scheduler to run a new selection round. The request goes out as a one-cycle trigger pulse. While the bus is in intermission with no buffer locked, or while a selection round is still running, the request waits. It fires in the cycle after the blocking condition ends. Several writes that arrive during the wait produce a single pulse. While snoop mode is enabled, the flags and any waiting request are held cleared.

Top module: `txrdy_req_reg`

## Requirements
- R1: After a synchronous reset, all flag bits and the trigger are 0. Bit N of every vector belongs to buffer N, for N = 0 to 31.
- R2: When wr_en is high, each bit of wr_data that is 1 sets the matching flag. The flag is visible one cycle later. Bits of wr_data that are 0 change nothing.
- R3: Writing 1 to a flag that is already 1 leaves it at 1 and has no other effect.
- R4: A 1 on bit N of tx_done clears flag N in the next cycle.
- R5: A 1 on bit N of attempt_end clears flag N only while single_shot is 1. While single_shot is 0, attempt_end has no effect.
- R6: A 1 on bit N of cancel_ack clears flag N. Several clear sources may hit the same bit or different bits in one cycle.
- R7: If a set and a clear reach the same bit in the same cycle, the flag is 0 afterwards.
- R8: Any host write, including one with all-zero data, produces a one-cycle sched_trigger pulse in the next cycle when nothing holds it back.
- R9: The scheduling request is held back while (bus_intermission is 1 and buf_locked is 0) or sched_busy is 1. sched_trigger then fires in the cycle after the hold ends. Intermission with a locked buffer does not hold the request.
- R10: Any number of writes made while the request is held back give exactly one trigger pulse.
- R11: While snoop_en is 1, the flags read 0, writes are ignored, any held-back request is dropped, and no trigger is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe for the register |
| wr_data | input | 32 | Host write data, 1 = request buffer N |
| tx_done | input | 32 | Successful transmission pulses, one per buffer |
| attempt_end | input | 32 | End-of-attempt pulses, one per buffer (success, lost arbitration or error) |
| cancel_ack | input | 32 | Cancellation-completed pulses, one per buffer |
| single_shot | input | 1 | Automatic retransmission disabled |
| snoop_en | input | 1 | Snoop mode, holds the register cleared |
| bus_intermission | input | 1 | Bus is in the 3-bit intermission field |
| buf_locked | input | 1 | A buffer is locked for the next transmission |
| sched_busy | input | 1 | A scheduling round is in progress |
| ready_flags | output | 32 | Current pending-request flags |
| sched_trigger | output | 1 | One-cycle request to start a scheduling round |

## Verification
On every cycle the assertions check the behaviour of each flag bit: a clear always wins, an unblocked set lands, a flag never rises without a write, and snoop mode forces the flag to 0. They also check that a held-back request never fires while the hold is active, and that an unblocked write or a waiting request fires in the next cycle. The bench scenarios are needed for behaviour that spans several cycles. These are the merging of many held-back writes into exactly one pulse, the release timing after long holds, the effect of attempt_end with and without single-shot mode, and the loss of a waiting request when snoop mode is entered.

// File: rtl/txrdy_pkg.sv
package txrdy_pkg;

    localparam int unsigned NBUF_DEF = 32;

    // Clear sources that act on one buffer in one cycle
    typedef struct packed {
        logic done;
        logic attempt;
        logic cancel;
    } clr_src_t;

    // State of the rescheduling request
    typedef enum logic [0:0] {
        RS_IDLE  = 1'b0,
        RS_DEFER = 1'b1
    } resched_st_t;

    // An attempt end only counts in single-shot mode
    function automatic logic clear_hit(input clr_src_t s, input logic single);
        return s.done | s.cancel | (s.attempt & single);
    endfunction

    // Conditions that keep a scheduling request waiting
    function automatic logic sched_hold(input logic inter, input logic locked,
                                        input logic busy);
        return (inter & ~locked) | busy;
    endfunction

endpackage

// File: rtl/txrdy_clear_merge.sv
module txrdy_clear_merge
    import txrdy_pkg::*;
#(
    parameter int unsigned NBUF = NBUF_DEF
) (
    input  logic [NBUF-1:0] tx_done,
    input  logic [NBUF-1:0] attempt_end,
    input  logic [NBUF-1:0] cancel_ack,
    input  logic            single_shot,
    output logic [NBUF-1:0] clr_vec
);

    for (genvar i = 0; i < NBUF; i++) begin : g_bit
        clr_src_t src;
        always_comb begin
            src.done    = tx_done[i];
            src.attempt = attempt_end[i];
            src.cancel  = cancel_ack[i];
            clr_vec[i]  = clear_hit(src, single_shot);
        end
    end

endmodule

// File: rtl/txrdy_bit_cell.sv
module txrdy_bit_cell (
    input  logic clk,
    input  logic rst,
    input  logic snoop,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst || snoop) begin
            flag <= 1'b0;
        end else if (clr_req) begin
            flag <= 1'b0;
        end else if (set_req) begin
            flag <= 1'b1;
        end
    end

    // R7 / R4 / R6: a clear in any form leaves the flag low
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> !flag);

    // R2: an unblocked set lands one cycle later
    p_set_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (set_req && !clr_req && !snoop) |=> flag);

    // R3: a set on a flag already high keeps it high
    p_set_on_one_r3: assert property (@(posedge clk) disable iff (rst)
        (flag && set_req && !clr_req && !snoop) |=> flag);

    // R2: a flag never rises without a write
    p_no_spont_r2: assert property (@(posedge clk) disable iff (rst)
        (!flag && !set_req) |=> !flag);

    // R11: snoop mode holds the flag cleared
    p_snoop_clr_r11: assert property (@(posedge clk) disable iff (rst)
        snoop |=> !flag);

endmodule

// File: rtl/txrdy_resched.sv
module txrdy_resched
    import txrdy_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic snoop,
    input  logic wr_en,
    input  logic bus_intermission,
    input  logic buf_locked,
    input  logic sched_busy,
    output logic sched_trigger
);

    resched_st_t st_q;
    logic        hold;
    logic        want;

    always_comb begin
        hold = sched_hold(bus_intermission, buf_locked, sched_busy);
        want = wr_en | (st_q == RS_DEFER);
    end

    always_ff @(posedge clk) begin
        if (rst || snoop) begin
            st_q          <= RS_IDLE;
            sched_trigger <= 1'b0;
        end else begin
            sched_trigger <= want & ~hold;
            st_q          <= (want & hold) ? RS_DEFER : RS_IDLE;
        end
    end

    // R8: an unblocked write fires in the next cycle
    p_write_fires_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hold && !snoop) |=> sched_trigger);

    // R9: nothing fires while the hold is active
    p_hold_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        hold |=> !sched_trigger);

    // R10: a waiting request fires once the hold ends
    p_pending_fires_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == RS_DEFER && !hold && !snoop) |=> (sched_trigger && st_q == RS_IDLE));

    // R11: snoop mode drops the request and blocks the pulse
    p_snoop_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        snoop |=> (!sched_trigger && st_q == RS_IDLE));

endmodule

// File: rtl/txrdy_req_reg.sv
module txrdy_req_reg
    import txrdy_pkg::*;
#(
    parameter int unsigned NBUF = NBUF_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [NBUF-1:0] wr_data,
    input  logic [NBUF-1:0] tx_done,
    input  logic [NBUF-1:0] attempt_end,
    input  logic [NBUF-1:0] cancel_ack,
    input  logic            single_shot,
    input  logic            snoop_en,
    input  logic            bus_intermission,
    input  logic            buf_locked,
    input  logic            sched_busy,
    output logic [NBUF-1:0] ready_flags,
    output logic            sched_trigger
);

    logic [NBUF-1:0] clr_vec;
    logic [NBUF-1:0] set_vec;

    assign set_vec = wr_data & {NBUF{wr_en}};

    txrdy_clear_merge #(.NBUF(NBUF)) u_clear (
        .tx_done     (tx_done),
        .attempt_end (attempt_end),
        .cancel_ack  (cancel_ack),
        .single_shot (single_shot),
        .clr_vec     (clr_vec)
    );

    for (genvar i = 0; i < NBUF; i++) begin : g_cell
        txrdy_bit_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .snoop   (snoop_en),
            .set_req (set_vec[i]),
            .clr_req (clr_vec[i]),
            .flag    (ready_flags[i])
        );
    end

    txrdy_resched u_resched (
        .clk              (clk),
        .rst              (rst),
        .snoop            (snoop_en),
        .wr_en            (wr_en),
        .bus_intermission (bus_intermission),
        .buf_locked       (buf_locked),
        .sched_busy       (sched_busy),
        .sched_trigger    (sched_trigger)
    );

    // R5: without single-shot mode, an attempt end alone never lowers a flag
    p_attempt_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (!single_shot && !snoop_en) |=>
            ((($past(ready_flags) | $past(set_vec)) & ~$past(tx_done) & ~$past(cancel_ack))
              & ~ready_flags) == '0);

    // R1: out of reset the register is empty and quiet
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (ready_flags == '0 && !sched_trigger));

endmodule

// File: tb/txrdy_req_reg_bench.sv
module txrdy_req_reg_bench;

    localparam int NB = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [NB-1:0] wr_data = '0;
    logic [NB-1:0] tx_done = '0;
    logic [NB-1:0] attempt_end = '0;
    logic [NB-1:0] cancel_ack = '0;
    logic          single_shot = 1'b0;
    logic          snoop_en = 1'b0;
    logic          bus_intermission = 1'b0;
    logic          buf_locked = 1'b0;
    logic          sched_busy = 1'b0;
    logic [NB-1:0] ready_flags;
    logic          sched_trigger;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";

    always #2ns clk = ~clk;

    txrdy_req_reg u_txrdy_req_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .tx_done(tx_done), .attempt_end(attempt_end), .cancel_ack(cancel_ack),
        .single_shot(single_shot), .snoop_en(snoop_en),
        .bus_intermission(bus_intermission), .buf_locked(buf_locked),
        .sched_busy(sched_busy), .ready_flags(ready_flags),
        .sched_trigger(sched_trigger)
    );

    // Behavioural reference model
    bit [NB-1:0] m_flags = '0;
    bit          m_waiting = 1'b0;
    bit          m_trig = 1'b0;

    always @(posedge clk) begin
        bit [NB-1:0] nf;
        bit blocked;
        bit asked;
        if (rst || snoop_en) begin
            m_flags   <= '0;
            m_waiting <= 1'b0;
            m_trig    <= 1'b0;
        end else begin
            for (int i = 0; i < NB; i++) begin
                if (tx_done[i] || cancel_ack[i] || (single_shot && attempt_end[i]))
                    nf[i] = 1'b0;
                else if (wr_en && wr_data[i])
                    nf[i] = 1'b1;
                else
                    nf[i] = m_flags[i];
            end
            blocked = sched_busy || (bus_intermission && !buf_locked);
            asked   = wr_en || m_waiting;
            m_flags   <= nf;
            m_trig    <= asked && !blocked;
            m_waiting <= asked && blocked;
        end
    end

    task automatic check(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock; afterwards compare against the model away from the edge
    task automatic tick();
        @(posedge clk);
        #1ns;
        check({cur_req, " flags vs model"}, ready_flags, m_flags);
        check({cur_req, " trigger vs model"}, {31'b0, sched_trigger}, {31'b0, m_trig});
    endtask

    task automatic quiet();
        wr_en = 0; wr_data = '0; tx_done = '0; attempt_end = '0; cancel_ack = '0;
    endtask

    task automatic host_write(input logic [NB-1:0] d);
        wr_en = 1; wr_data = d;
        tick();
        quiet();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1ns;
        check("R1 reset flags", ready_flags, '0);
        check("R1 reset trigger", {31'b0, sched_trigger}, '0);
        rst = 0;
        tick();

        cur_req = "R2";
        host_write(32'h0000_00A5);
        check("R2 set pattern", ready_flags, 32'h0000_00A5);
        check("R8 trigger after write", {31'b0, sched_trigger}, 32'd1);
        tick();
        check("R8 trigger one cycle", {31'b0, sched_trigger}, '0);

        cur_req = "R8";
        host_write('0);
        check("R2 zero write keeps flags", ready_flags, 32'h0000_00A5);
        check("R8 zero write triggers", {31'b0, sched_trigger}, 32'd1);
        tick();

        cur_req = "R1";
        host_write(32'h8000_0000);
        check("R1 bit 31 maps to buffer 31", ready_flags, 32'h8000_00A5);

        cur_req = "R3";
        host_write(32'h0000_0101);
        check("R3 set on one ignored", ready_flags, 32'h8000_01A5);

        cur_req = "R4";
        tx_done = 32'h0000_0001; tick(); quiet();
        check("R4 done clears", ready_flags, 32'h8000_01A4);

        cur_req = "R5";
        single_shot = 0; attempt_end = 32'h0000_0004; tick(); quiet();
        check("R5 attempt ignored", ready_flags, 32'h8000_01A4);
        single_shot = 1; attempt_end = 32'h0000_0004; tick(); quiet();
        check("R5 attempt clears in single shot", ready_flags, 32'h8000_01A0);
        single_shot = 0;

        cur_req = "R6";
        cancel_ack = 32'h0000_00A0; tx_done = 32'h8000_0100; tick(); quiet();
        check("R6 combined clears", ready_flags, '0);

        cur_req = "R7";
        wr_en = 1; wr_data = 32'h0000_0018; cancel_ack = 32'h0000_0008; tick(); quiet();
        check("R7 clear beats set", ready_flags, 32'h0000_0010);
        tick();

        cur_req = "R9";
        sched_busy = 1;
        host_write(32'h0000_0001);
        check("R9 busy holds", {31'b0, sched_trigger}, '0);
        tick(); tick();
        check("R9 still held", {31'b0, sched_trigger}, '0);
        sched_busy = 0;
        tick();
        check("R9 fires after hold", {31'b0, sched_trigger}, 32'd1);
        tick();
        check("R9 single pulse", {31'b0, sched_trigger}, '0);

        bus_intermission = 1; buf_locked = 0;
        host_write('0);
        check("R9 intermission holds", {31'b0, sched_trigger}, '0);
        buf_locked = 1;
        tick();
        check("R9 locked intermission releases", {31'b0, sched_trigger}, 32'd1);
        host_write('0);
        check("R9 locked intermission no hold", {31'b0, sched_trigger}, 32'd1);
        bus_intermission = 0; buf_locked = 0;
        tick();

        cur_req = "R10";
        sched_busy = 1;
        host_write(32'h0000_0100);
        host_write(32'h0000_0200);
        host_write(32'h0000_0400);
        tick();
        sched_busy = 0;
        tick();
        check("R10 merged pulse", {31'b0, sched_trigger}, 32'd1);
        tick();
        check("R10 no second pulse", {31'b0, sched_trigger}, '0);
        tick();
        check("R10 still quiet", {31'b0, sched_trigger}, '0);

        cur_req = "R11";
        host_write(32'hFFFF_0000);
        snoop_en = 1;
        tick();
        check("R11 snoop clears flags", ready_flags, '0);
        host_write(32'h0000_FFFF);
        check("R11 write ignored", ready_flags, '0);
        check("R11 no trigger", {31'b0, sched_trigger}, '0);
        snoop_en = 0;
        sched_busy = 1;
        host_write(32'h0000_0001);
        snoop_en = 1;
        tick();
        snoop_en = 0; sched_busy = 0;
        tick();
        check("R11 held request dropped", {31'b0, sched_trigger}, '0);
        check("R11 flags after snoop", ready_flags, '0);

        repeat (4) tick();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100us;
        total++;
        bad++;
        $display("FAIL watchdog %s actual=running expected=finished", cur_req);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule